// File: doc/BRIEF.md
# Cascaded 32-bit Timer with Coherent Word Access

The block holds two 16-bit timer halves behind one 16-bit register bus. Each half has its own clock front end, its own period register and its own event output, and counts on its own. When the pairing bit in the low half's control word is set, the two halves act as a single 32-bit counter. The low word counts the prescaled ticks. The high word advances only when the low word carries out. The full 32-bit value is compared against the two period words taken together. In this mode the low half's control word alone selects the clock source, the prescale, the gating and the enable.

Software works with the 32-bit value through 16-bit accesses, and a holding register keeps those accesses coherent. Reading the low count word captures the high count word into the holding register in the same access, so a later read of the holding register returns the matching upper half. To load the counter, software writes the upper half into the holding register first. A later write of the low count word then commits the holding value into the high count word on the same clock edge.

A one-cycle converter trigger pulse marks each period match of the high half in 16-bit mode, and each match of the full 32-bit period in paired mode. An external pin per half serves either as a counted clock or as a gate. The pin is always sampled through a two-flop synchronizer.

Top module: `casc_timer32`

## Requirements
- R1: After reset every register reads zero and evt_lo, evt_hi and adc_trig are low. The register addresses are 0 low count, 1 high count, 2 holding, 3 low period, 4 high period, 5 low control and 6 high control; address 7 reads zero. In a control word, bit 0 enables counting, bit 1 selects the external pin as the clock, bit 2 enables gating and bits 5:4 select the prescale. Bit 3 of the low control word selects paired mode.
- R2: In 16-bit mode each half counts its own ticks. On a tick where its count equals its period it returns to zero, and its event output pulses high for one cycle after that edge. A period of zero produces no event.
- R3: Prescale codes 0, 1, 2 and 3 give one tick every 1, 8, 64 and 256 source clocks. The prescaler restarts when counting is disabled and when the count it drives is written.
- R4: In paired mode the high count word changes only on a carry out of the low word at 0xFFFF, on a 32-bit wrap or on a bus write. The high control word has no effect.
- R5: In paired mode a tick at which {high count, low count} equals {high period, low period} returns both words to zero, and only evt_hi pulses. evt_lo stays low. A period of 0xFFFFFFFF counts through the full 32-bit range.
- R6: In paired mode a read of the low count word copies the high count word, as it stands in that same cycle, into the holding register. A later read of address 2 returns that copy.
- R7: In paired mode a write of the low count word loads the bus data into the low word and the holding value into the high word on the same edge. Neither word increments in that cycle.
- R8: In 16-bit mode a read or write of the low count word neither changes the holding register nor changes the high count word.
- R9: adc_trig pulses for one cycle after a tick at which the high half matches a nonzero high period in 16-bit mode, or after a tick at which the 32-bit count matches a nonzero 32-bit period in paired mode.
- R10: With the external clock selected, each rising edge on the pin, seen through a two-flop synchronizer, is one source clock.
- R11: With gating enabled and the internal clock selected, the count advances once per prescaled cycle while the synchronized pin is high. A falling pin edge gives one event pulse, and a period match gives none.
- R12: Clearing the pairing bit returns both halves to independent counting and keeps both count values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, valid in the same cycle |
| pin_lo | input | 1 | External clock or gate pin of the low half |
| pin_hi | input | 1 | External clock or gate pin of the high half |
| evt_lo | output | 1 | One-cycle event pulse of the low half (16-bit mode only) |
| evt_hi | output | 1 | One-cycle event pulse of the high half or of the 32-bit pair |
| adc_trig | output | 1 | One-cycle converter trigger on period match |

## Verification
Some rules are checked on every cycle, for any stimulus, by properties placed beside the logic. The high word moves only on a carry, a wrap or a write. Both words are zero after a 32-bit wrap. The holding register receives the previous high word after a paired low read. A loaded word takes the load value. The trigger never lasts two cycles. The prescaler is zero after a clear. Other behaviour shows only in the bench scenarios, which compare read data and event outputs against a cycle model. These cover the exact tick spacing of each prescale code, event timing and the silence at period zero, the commit through the holding register and the indifference of the high control word. They also cover the kept counts when pairing is cleared, pin edge counting through the synchronizer, and the gated count with its single falling-edge event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_HOLD   = 3'd2,
    A_PER_LO = 3'd3,
    A_PER_HI = 3'd4,
    A_CTL_LO = 3'd5,
    A_CTL_HI = 3'd6
  } reg_addr_e;

  // control word bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_EXT  = 1;
  localparam int CB_GATE = 2;
  localparam int CB_PAIR = 3;
  localparam int CB_PS   = 4;
  localparam int PS_W    = 2;

  // last prescaler count for each code (divide minus one)
  function automatic logic [7:0] presc_last(input logic [PS_W-1:0] code);
    case (code)
      2'd0:    presc_last = 8'd0;
      2'd1:    presc_last = 8'd7;
      2'd2:    presc_last = 8'd63;
      default: presc_last = 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/tmr_front.sv
module tmr_front
  import tmr_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin,
  input  logic            run,
  input  logic            ext_sel,
  input  logic            gate_en,
  input  logic [PS_W-1:0] ps,
  input  logic            clr,
  output logic            tick,
  output logic            gate_fall
);

  logic             s1_q, s2_q, s3_q;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] pre_last;
  logic             gated, rise, src, at_last;

  always_comb begin
    pre_last  = PRE_W'(presc_last(ps));
    gated     = gate_en & ~ext_sel;
    rise      = s2_q & ~s3_q;
    if (ext_sel)    src = rise;
    else if (gated) src = s2_q;
    else            src = 1'b1;
    at_last   = (pre_q == pre_last);
    tick      = run & ~clr & src & at_last;
    gate_fall = run & gated & s3_q & ~s2_q;
    if (clr)          pre_d = '0;
    else if (!src)    pre_d = pre_q;
    else if (at_last) pre_d = '0;
    else              pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      pre_q <= '0;
    end else begin
      s1_q  <= pin;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      pre_q <= pre_d;
    end
  end

  // R3: a cleared prescaler restarts from zero
  assert_pre_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));

endmodule

// File: rtl/tmr_word.sv
module tmr_word #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         zero,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (ld)        cnt_d = ld_val;
    else if (zero) cnt_d = '0;
    else if (inc)  cnt_d = cnt_q + W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7: a bus load lands exactly, with no increment on top
  assert_load_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/casc_timer32.sv
module casc_timer32
  import tmr_pkg::*;
#(
  parameter int CW    = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  input  logic              pin_lo,
  input  logic              pin_hi,
  output logic              evt_lo,
  output logic              evt_hi,
  output logic              adc_trig
);

  localparam int            NH      = 2;
  localparam int            DW      = 2 * CW;
  localparam logic [CW-1:0] ALL1    = '1;
  localparam logic [CW-1:0] MASK_LO = CW'(6'h3F);
  localparam logic [CW-1:0] MASK_HI = CW'(6'h37);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_ni = rs2_q;

  // register state
  logic [CW-1:0] ctl_lo_q, ctl_hi_q, per_lo_q, per_hi_q, hold_q;
  logic [CW-1:0] ctl_lo_d, ctl_hi_d, per_lo_d, per_hi_d, hold_d;
  logic          evt_lo_q, evt_hi_q, trig_q;
  logic          evt_lo_d, evt_hi_d, trig_d;

  // bus decode
  logic wr_lo, wr_hi, wr_hold, wr_plo, wr_phi, wr_clo, wr_chi, rd_lo, cnt_wr;
  always_comb begin
    wr_lo   = bus_wr & (bus_addr == A_CNT_LO);
    wr_hi   = bus_wr & (bus_addr == A_CNT_HI);
    wr_hold = bus_wr & (bus_addr == A_HOLD);
    wr_plo  = bus_wr & (bus_addr == A_PER_LO);
    wr_phi  = bus_wr & (bus_addr == A_PER_HI);
    wr_clo  = bus_wr & (bus_addr == A_CTL_LO);
    wr_chi  = bus_wr & (bus_addr == A_CTL_HI);
    rd_lo   = bus_rd & (bus_addr == A_CNT_LO);
    cnt_wr  = wr_lo | wr_hi;
  end

  // per-half front ends and count words
  logic [NH-1:0]           f_pin, f_run, f_ext, f_gate, f_clr, f_tick, f_fall;
  logic [NH-1:0][PS_W-1:0] f_ps;
  logic [NH-1:0]           w_ld, w_zero, w_inc;
  logic [NH-1:0][CW-1:0]   w_val, w_cnt;
  logic [NH-1:0][CW-1:0]   ctl_v;

  genvar h;
  generate
    for (h = 0; h < NH; h++) begin : g_half
      tmr_front #(.PRE_W(PRE_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_ni),
        .pin       (f_pin[h]),
        .run       (f_run[h]),
        .ext_sel   (f_ext[h]),
        .gate_en   (f_gate[h]),
        .ps        (f_ps[h]),
        .clr       (f_clr[h]),
        .tick      (f_tick[h]),
        .gate_fall (f_fall[h])
      );
      tmr_word #(.W(CW)) u_word (
        .clk    (clk),
        .rst_n  (rst_ni),
        .ld     (w_ld[h]),
        .ld_val (w_val[h]),
        .zero   (w_zero[h]),
        .inc    (w_inc[h]),
        .cnt    (w_cnt[h])
      );
    end
  endgenerate

  // counting control
  logic          pair, gm_lo, gm_hi;
  logic [CW-1:0] cnt_lo, cnt_hi;
  logic [DW-1:0] cnt32, per32;
  logic          match_lo, match_hi, match32, carry;

  always_comb begin
    pair     = ctl_lo_q[CB_PAIR];
    ctl_v[0] = ctl_lo_q;
    ctl_v[1] = ctl_hi_q;
    f_pin[0] = pin_lo;
    f_pin[1] = pin_hi;
    for (int i = 0; i < NH; i++) begin
      f_ext[i]  = ctl_v[i][CB_EXT];
      f_gate[i] = ctl_v[i][CB_GATE];
      f_ps[i]   = ctl_v[i][CB_PS +: PS_W];
    end
    // the high front sleeps while paired; its control word is ignored
    f_run[0] = ctl_lo_q[CB_RUN];
    f_run[1] = ctl_hi_q[CB_RUN] & ~pair;
    f_clr[0] = ~f_run[0] | wr_lo | (pair & wr_hi);
    f_clr[1] = ~f_run[1] | wr_hi;

    gm_lo    = ctl_lo_q[CB_GATE] & ~ctl_lo_q[CB_EXT];
    gm_hi    = ctl_hi_q[CB_GATE] & ~ctl_hi_q[CB_EXT];

    cnt_lo   = w_cnt[0];
    cnt_hi   = w_cnt[1];
    cnt32    = {cnt_hi, cnt_lo};
    per32    = {per_hi_q, per_lo_q};
    match_lo = f_tick[0] & (cnt_lo == per_lo_q);
    match_hi = f_tick[1] & (cnt_hi == per_hi_q);
    match32  = f_tick[0] & (cnt32 == per32);
    carry    = f_tick[0] & (cnt_lo == ALL1);

    w_ld[0]   = wr_lo;
    w_val[0]  = bus_wdata;
    w_zero[0] = pair ? match32 : match_lo;
    w_inc[0]  = f_tick[0];

    w_ld[1]   = wr_hi | (pair & wr_lo);
    w_val[1]  = (pair & wr_lo) ? hold_q : bus_wdata;
    w_zero[1] = pair ? match32 : match_hi;
    w_inc[1]  = pair ? carry : f_tick[1];
  end

  // events and trigger
  always_comb begin
    evt_lo_d = ~pair & ((match_lo & (per_lo_q != '0) & ~gm_lo) | f_fall[0]);
    if (pair) begin
      evt_hi_d = (match32 & (per32 != '0) & ~gm_lo) | f_fall[0];
      trig_d   = match32 & (per32 != '0);
    end else begin
      evt_hi_d = (match_hi & (per_hi_q != '0) & ~gm_hi) | f_fall[1];
      trig_d   = match_hi & (per_hi_q != '0);
    end
  end

  // register next state
  always_comb begin
    ctl_lo_d = wr_clo ? (bus_wdata & MASK_LO) : ctl_lo_q;
    ctl_hi_d = wr_chi ? (bus_wdata & MASK_HI) : ctl_hi_q;
    per_lo_d = wr_plo ? bus_wdata : per_lo_q;
    per_hi_d = wr_phi ? bus_wdata : per_hi_q;
    if (wr_hold)             hold_d = bus_wdata;
    else if (pair && rd_lo)  hold_d = cnt_hi;
    else                     hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_lo_q <= '0;
      ctl_hi_q <= '0;
      per_lo_q <= '0;
      per_hi_q <= '0;
      hold_q   <= '0;
      evt_lo_q <= 1'b0;
      evt_hi_q <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      ctl_lo_q <= ctl_lo_d;
      ctl_hi_q <= ctl_hi_d;
      per_lo_q <= per_lo_d;
      per_hi_q <= per_hi_d;
      hold_q   <= hold_d;
      evt_lo_q <= evt_lo_d;
      evt_hi_q <= evt_hi_d;
      trig_q   <= trig_d;
    end
  end

  // read mux
  always_comb begin
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_lo;
      A_CNT_HI: bus_rdata = cnt_hi;
      A_HOLD:   bus_rdata = hold_q;
      A_PER_LO: bus_rdata = per_lo_q;
      A_PER_HI: bus_rdata = per_hi_q;
      A_CTL_LO: bus_rdata = ctl_lo_q;
      A_CTL_HI: bus_rdata = ctl_hi_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign evt_lo   = evt_lo_q;
  assign evt_hi   = evt_hi_q;
  assign adc_trig = trig_q;

  // R4: while paired, the high word moves only by carry, wrap or write
  assert_hi_carry_only_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (pair && !cnt_wr && (cnt_lo != ALL1) && !match32) |=> $stable(cnt_hi));

  // R5: a 32-bit match leaves both words at zero
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (pair && match32 && !cnt_wr) |=> (cnt_lo == '0 && cnt_hi == '0));

  // R6: a paired low read leaves the prior high word in the holding register
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (pair && rd_lo && !wr_hold) |=> (hold_q == $past(cnt_hi)));

  // R9: the trigger is a single-cycle pulse
  assert_trig_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    trig_q |=> !trig_q);

endmodule

// File: tb/casc_timer32_test.sv
module casc_timer32_test;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pin_lo = 1'b0, pin_hi = 1'b0;
  logic        evt_lo, evt_hi, adc_trig;

  int unsigned total = 0, bad = 0;
  bit          done = 1'b0;
  bit          model_on = 1'b0;
  int unsigned n_evt_lo = 0, n_evt_hi = 0;

  // model state
  logic [15:0] m_lo, m_hi, m_hold, m_plo, m_phi, m_cl, m_ch;
  logic [7:0]  m_pl, m_ph;
  logic        e_lo, e_hi, e_tr;

  casc_timer32 uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_lo(pin_lo), .pin_hi(pin_hi), .evt_lo(evt_lo), .evt_hi(evt_hi),
    .adc_trig(adc_trig)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (evt_lo) n_evt_lo++;
    if (evt_hi) n_evt_hi++;
  end

  function automatic logic [7:0] plast(input logic [1:0] c);
    case (c)
      2'd0: plast = 8'd0;
      2'd1: plast = 8'd7;
      2'd2: plast = 8'd63;
      default: plast = 8'd255;
    endcase
  endfunction

  function automatic logic [15:0] mread(input logic [2:0] a);
    case (a)
      3'd0: mread = m_lo;
      3'd1: mread = m_hi;
      3'd2: mread = m_hold;
      3'd3: mread = m_plo;
      3'd4: mread = m_phi;
      3'd5: mread = m_cl;
      3'd6: mread = m_ch;
      default: mread = 16'h0;
    endcase
  endfunction

  task automatic chk16(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_hold = 0; m_plo = 0; m_phi = 0; m_cl = 0; m_ch = 0;
    m_pl = 0; m_ph = 0; e_lo = 0; e_hi = 0; e_tr = 0;
  endtask

  // next state from the requirements, internal clock and no gating
  task automatic model_step(input logic w, input logic r, input logic [2:0] a, input logic [15:0] d);
    logic pair, wlo, whi, run_l, run_h, clr_l, clr_h, tk_l, tk_h, mt32, mt_l, mt_h;
    logic [15:0] n_lo, n_hi;
    logic [7:0]  ll, lh;
    pair  = m_cl[3];
    wlo   = w && a == 3'd0;
    whi   = w && a == 3'd1;
    run_l = m_cl[0];
    run_h = m_ch[0] && !pair;
    clr_l = !run_l || wlo || (pair && whi);
    clr_h = !run_h || whi;
    ll = plast(m_cl[5:4]);
    lh = plast(m_ch[5:4]);
    tk_l = run_l && !clr_l && m_pl == ll;
    tk_h = run_h && !clr_h && m_ph == lh;
    if (pair) begin
      mt32 = tk_l && {m_hi, m_lo} == {m_phi, m_plo};
      n_lo = wlo ? d : mt32 ? 16'h0 : tk_l ? m_lo + 16'h1 : m_lo;
      n_hi = wlo ? m_hold : whi ? d : mt32 ? 16'h0 :
             (tk_l && m_lo == 16'hFFFF) ? m_hi + 16'h1 : m_hi;
      e_lo = 1'b0;
      e_hi = mt32 && {m_phi, m_plo} != 32'h0;
      e_tr = e_hi;
    end else begin
      mt_l = tk_l && m_lo == m_plo;
      mt_h = tk_h && m_hi == m_phi;
      n_lo = wlo ? d : mt_l ? 16'h0 : tk_l ? m_lo + 16'h1 : m_lo;
      n_hi = whi ? d : mt_h ? 16'h0 : tk_h ? m_hi + 16'h1 : m_hi;
      e_lo = mt_l && m_plo != 16'h0;
      e_hi = mt_h && m_phi != 16'h0;
      e_tr = e_hi;
    end
    if (w && a == 3'd2) m_hold = d;
    else if (r && a == 3'd0 && pair) m_hold = m_hi;
    m_pl = clr_l ? 8'h0 : (m_pl == ll ? 8'h0 : m_pl + 8'h1);
    m_ph = clr_h ? 8'h0 : (m_ph == lh ? 8'h0 : m_ph + 8'h1);
    m_lo = n_lo;
    m_hi = n_hi;
    if (w && a == 3'd3) m_plo = d;
    if (w && a == 3'd4) m_phi = d;
    if (w && a == 3'd5) m_cl = d & 16'h003F;
    if (w && a == 3'd6) m_ch = d & 16'h0037;
  endtask

  task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    if (model_on) begin
      chk1(evt_lo, e_lo, "R2 R5 evt_lo");
      chk1(evt_hi, e_hi, "R2 R5 evt_hi");
      chk1(adc_trig, e_tr, "R9 trigger");
    end
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    #1;
    if (model_on && r) chk16(bus_rdata, mread(a), tag);
    if (model_on) model_step(w, r, a, d);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 16'h0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 16'h0, "idle");
  endtask
  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    rd(a, tag);
    chk16(bus_rdata, exp, tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int unsigned r, base_lo, base_hi;
    void'($urandom(32'd1357));
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 16'h0, "R1");

    // R7 commit through holding register, R6 snapshot
    wr(3'd5, 16'h0008, "R4");
    wr(3'd2, 16'h1234, "R7");
    wr(3'd0, 16'hFFFE, "R7");
    rd_chk(3'd1, 16'h1234, "R7");
    rd_chk(3'd0, 16'hFFFE, "R6");
    rd_chk(3'd2, 16'h1234, "R6");
    wr(3'd3, 16'hFFFF, "R5");
    wr(3'd4, 16'hFFFF, "R5");
    wr(3'd5, 16'h0009, "R4");
    idle(2);
    rd(3'd0, "R6");
    rd_chk(3'd2, 16'h1235, "R6");

    // R5 full-range wrap
    wr(3'd5, 16'h0008, "R5");
    wr(3'd2, 16'hFFFF, "R5");
    wr(3'd0, 16'hFFFC, "R5");
    wr(3'd5, 16'h0009, "R5");
    base_hi = n_evt_hi;
    idle(8);
    total++;
    if (n_evt_hi - base_hi != 1) begin
      bad++;
      $display("FAIL R5: got %0d wrap events expected 1", n_evt_hi - base_hi);
    end

    // R4 high control ignored while paired
    wr(3'd6, 16'h0001, "R4");
    idle(10);
    rd(3'd1, "R4");

    // R12 leave paired mode, counts kept
    rd(3'd0, "R12");
    wr(3'd5, 16'h0001, "R12");
    rd(3'd0, "R12");
    rd(3'd1, "R12");

    // R8 holding register unused in 16-bit mode
    wr(3'd6, 16'h0000, "R8");
    wr(3'd2, 16'h5555, "R8");
    rd(3'd1, "R8");
    wr(3'd0, 16'h0100, "R8");
    rd(3'd0, "R8");
    rd_chk(3'd2, 16'h5555, "R8");
    rd(3'd1, "R8");

    // R3 prescale spacing
    wr(3'd5, 16'h0011, "R3");
    wr(3'd0, 16'h0000, "R3");
    idle(20);
    rd(3'd0, "R3");
    wr(3'd5, 16'h0021, "R3");
    wr(3'd0, 16'h0000, "R3");
    idle(140);
    rd(3'd0, "R3");
    wr(3'd5, 16'h0031, "R3");
    wr(3'd0, 16'h0000, "R3");
    idle(520);
    rd(3'd0, "R3");

    // R2 period zero quiet, R9 trigger from high half
    wr(3'd3, 16'h0000, "R2");
    wr(3'd0, 16'h0000, "R2");
    wr(3'd5, 16'h0001, "R2");
    wr(3'd4, 16'h0003, "R9");
    wr(3'd1, 16'h0000, "R9");
    wr(3'd6, 16'h0001, "R9");
    idle(12);
    rd(3'd0, "R2");

    // random phase
    for (int i = 0; i < 5000; i++) begin
      r = $urandom % 100;
      if (r < 38) idle(1);
      else if (r < 55) begin
        d = 16'(($urandom % 4 == 0) ? ($urandom % 8) : ($urandom % 3));
        rd(d[2:0], d[2:0] == 3'd2 ? "R6" : (d[2:0] == 3'd1 ? "R4" : "R2"));
      end else if (r < 63)
        wr(3'd0, ($urandom % 2) ? 16'(16'hFFF0 + $urandom % 16) : 16'($urandom % 16), "R7");
      else if (r < 68)
        wr(3'd2, ($urandom % 2) ? 16'hFFFF : 16'($urandom % 4), "R7");
      else if (r < 71) wr(3'd1, 16'($urandom % 8), "R4");
      else if (r < 75) begin
        r = $urandom % 4;
        wr(3'd3, r == 0 ? 16'h0 : r == 1 ? 16'hFFFF : 16'(1 + $urandom % 20), "R2");
      end else if (r < 78) begin
        r = $urandom % 4;
        wr(3'd4, r == 0 ? 16'h0 : r == 1 ? 16'hFFFF : 16'(1 + $urandom % 3), "R9");
      end else if (r < 83) begin
        r = $urandom % 8;
        d = 16'h0;
        d[0] = ($urandom % 4) != 0;
        d[3] = $urandom % 2;
        d[5:4] = r < 5 ? 2'd0 : r < 7 ? 2'd1 : 2'd2;
        wr(3'd5, d, "R4");
      end else if (r < 86) begin
        d = 16'h0;
        d[0] = $urandom % 2;
        d[5:4] = ($urandom % 3 == 0) ? 2'd1 : 2'd0;
        wr(3'd6, d, "R4");
      end else rd(3'd0, "R6");
    end
    idle(2);
    model_on = 1'b0;

    // R10 external pin clock
    wr(3'd5, 16'h0000, "R10");
    wr(3'd6, 16'h0000, "R10");
    wr(3'd3, 16'hFFFF, "R10");
    wr(3'd0, 16'h0000, "R10");
    wr(3'd5, 16'h0003, "R10");
    for (int k = 0; k < 5; k++) begin
      pin_lo = 1'b1; idle(4);
      pin_lo = 1'b0; idle(4);
    end
    idle(4);
    rd_chk(3'd0, 16'd5, "R10");

    // R11 gated accumulation
    wr(3'd5, 16'h0000, "R11");
    wr(3'd3, 16'h0003, "R11");
    wr(3'd0, 16'h0000, "R11");
    wr(3'd5, 16'h0005, "R11");
    base_lo = n_evt_lo;
    base_hi = n_evt_hi;
    pin_lo = 1'b1; idle(10);
    pin_lo = 1'b0; idle(6);
    rd_chk(3'd0, 16'd2, "R11");
    total++;
    if (n_evt_lo - base_lo != 1) begin
      bad++;
      $display("FAIL R11: got %0d gate events expected 1", n_evt_lo - base_lo);
    end
    total++;
    if (n_evt_hi != base_hi) begin
      bad++;
      $display("FAIL R11: got %0d high events expected 0", n_evt_hi - base_hi);
    end

    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule